// File: doc/BRIEF.md
# SDRAM Command and Byte-Mask Encoder

This block sits on the controller side of a 32-bit, four-bank synchronous DRAM. Each clock cycle it takes one abstract request (activate, read, write, precharge, no-operation, power-down entry or power-down exit) and turns it into registered pin-level values. Those values are chip select, the row, column and write strobes, the address bus, the two bank-select bits, clock enable and four byte-mask bits. Every output comes from a flop, so it stays stable at the edge where the memory samples it.

The address bus is filled according to the command. An activate drives the full row. A read or write drives only the column on the low bits and puts the auto-precharge flag on the top bit. A precharge uses the top bit to choose between all banks and a single bank. Byte masks follow each data burst: a write mask is driven in the same cycle as its data, and a read mask is driven early enough that the memory's two-cycle mask latency lines it up with the returning data.

Clock enable is dropped only when no burst is in flight. A power-down request that arrives during a burst is latched and held off. Until the burst counter runs out, the encoder drives no-operation with clock enable high. While powered down it keeps clock enable low and ignores every request except exit.

Top module: `sdram_cmd_encoder`

## Requirements
- R1: While `rst` is high and in the cycle after it, the command pins read {cs_n,ras_n,cas_n,we_n}=1111, `cke` is 1, `dqm` is 1111, and `addr` and `ba` are 0.
- R2: The request codes on `req_op` are 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 power-down entry and 6 power-down exit; 7 acts as nop. An activate presented in cycle n shows in cycle n+1 as command 0011, with `addr` equal to all 11 bits of `req_addr`.
- R3: A read (write) presented in cycle n shows in cycle n+1 as command 0101 (0100). `addr[7:0]` is the column `req_addr[7:0]`, `addr[9:8]` is 0 and `addr[10]` equals `req_auto_pre`.
- R4: A precharge shows as command 0010. With `req_all_banks`=1 it drives `addr`=0x400 and `ba`=00. Otherwise it drives `addr`=0 and `ba`=`req_bank`.
- R5: A nop request (or a power-down exit while running) gives command 0111 with `cke`=1 in the next cycle.
- R6: Bank field {ba[1],ba[0]} passes the requested bank unchanged: bank A=00, B=01, C=10, D=11, for activate, read, write and single-bank precharge.
- R7: For a write presented in cycle n, `dqm` equals `req_mask` in cycles n+1 to n+BURST_LEN, so the first mask coincides with the write command. Bit i masks byte i (bit 0 is data 7:0, bit 3 is data 31:24). With no burst window active `dqm` is 1111.
- R8: For a read presented in cycle n, `dqm` equals `req_mask` in cycles n+1+(CAS_LAT-2) to n+(CAS_LAT-2)+BURST_LEN, then returns to 1111.
- R9: A power-down entry with no burst in flight gives `cke`=0 and command 1111 in the next cycle.
- R10: A power-down entry presented in cycle n+1 after a read or write in cycle n gives command 0111 with `cke`=1 in cycles n+2 to n+BURST_LEN+1, ignoring other requests meanwhile. It gives `cke`=0 in cycle n+BURST_LEN+2.
- R11: While powered down, `cke` stays 0 and the command pins stay 1111 for every request except power-down exit. An exit in cycle n gives `cke`=1 and command 0111 in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 3 | Request code (see R2) |
| req_bank | input | 2 | Target bank |
| req_addr | input | 11 | Row (activate) or column in bits 7:0 (read/write) |
| req_auto_pre | input | 1 | Precharge automatically after a read or write burst |
| req_all_banks | input | 1 | Precharge targets all banks |
| req_mask | input | 4 | Byte mask for every beat of a read or write burst |
| cs_n | output | 1 | Chip select, low for a command cycle |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write strobe |
| addr | output | 11 | Memory address bus |
| ba | output | 2 | Bank select {ba[1],ba[0]} |
| cke | output | 1 | Clock enable |
| dqm | output | 4 | Byte mask, bit i for data byte i |

## Verification
Command, address, bank and clock-enable values are due one cycle after the request is presented. Write masks are due over the same cycles as the write command and its following beats, and read masks start CAS_LAT-2 cycles after the read command appears. A held-off power-down lands BURST_LEN+1 cycles after the request that asked for it. The driver stamps every expectation with the absolute cycle number computed from these offsets, and the monitor compares only the entries stamped for the current cycle, sampling on the falling edge once all flops have settled.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_PDN = 3'd5,
    OP_PUP = 3'd6,
    OP_RSV = 3'd7
  } sd_op_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_ACT   = 4'b0011;
  localparam logic [3:0] PIN_RD    = 4'b0101;
  localparam logic [3:0] PIN_WR    = 4'b0100;
  localparam logic [3:0] PIN_PRE   = 4'b0010;
  localparam logic [3:0] PIN_NOP   = 4'b0111;
  localparam logic [3:0] PIN_DESEL = 4'b1111;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_HOLD = 2'd1,
    PS_DOWN = 2'd2
  } pwr_st_e;

endpackage

// File: rtl/sdcmd_decode.sv
`timescale 1ns/1ps
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  sd_op_e              op,
  input  logic [BANK_W-1:0]   bank,
  input  logic [ROW_W-1:0]    addr_in,
  input  logic                auto_pre,
  input  logic                all_banks,
  output logic [3:0]          pins,
  output logic [ROW_W-1:0]    addr_out,
  output logic [BANK_W-1:0]   ba_out
);
  localparam int FLAG_BIT = ROW_W - 1;

  always_comb begin
    pins     = PIN_NOP;
    addr_out = '0;
    ba_out   = '0;
    unique case (op)
      OP_ACT: begin
        pins     = PIN_ACT;
        addr_out = addr_in;
        ba_out   = bank;
      end
      OP_RD, OP_WR: begin
        pins                  = (op == OP_RD) ? PIN_RD : PIN_WR;
        addr_out[COL_W-1:0]   = addr_in[COL_W-1:0];
        addr_out[FLAG_BIT]    = auto_pre;
        ba_out                = bank;
      end
      OP_PRE: begin
        pins               = PIN_PRE;
        addr_out[FLAG_BIT] = all_banks;
        ba_out             = all_banks ? '0 : bank;
      end
      default: begin
        pins = PIN_NOP;
      end
    endcase
  end

endmodule

// File: rtl/sdcmd_pwr.sv
`timescale 1ns/1ps
module sdcmd_pwr
  import sdcmd_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  sd_op_e op,
  output logic   pass,
  output logic   desel,
  output logic   cke_nxt,
  output logic   burst_go
);
  pwr_st_e          st_q, st_n;
  logic [CNT_W-1:0] left_q;
  logic             busy;

  assign busy = (left_q != '0);

  always_comb begin
    st_n    = st_q;
    pass    = 1'b0;
    desel   = 1'b0;
    cke_nxt = 1'b1;
    unique case (st_q)
      PS_RUN: begin
        if (op == OP_PDN) begin
          if (busy) begin
            st_n = PS_HOLD;
          end else begin
            st_n    = PS_DOWN;
            cke_nxt = 1'b0;
            desel   = 1'b1;
          end
        end else if (op != OP_PUP) begin
          pass = 1'b1;
        end
      end
      PS_HOLD: begin
        if (!busy) begin
          st_n    = PS_DOWN;
          cke_nxt = 1'b0;
          desel   = 1'b1;
        end
      end
      PS_DOWN: begin
        if (op == OP_PUP) begin
          st_n = PS_RUN;
        end else begin
          cke_nxt = 1'b0;
          desel   = 1'b1;
        end
      end
      default: st_n = PS_RUN;
    endcase
  end

  assign burst_go = pass && (op == OP_RD || op == OP_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_RUN;
      left_q <= '0;
    end else begin
      st_q <= st_n;
      if (burst_go) begin
        left_q <= CNT_W'(BURST_LEN);
      end else if (busy) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdcmd_mask.sv
`timescale 1ns/1ps
module sdcmd_mask #(
  parameter int MASK_W    = 4,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3,
  parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [MASK_W-1:0] mask_in,
  output logic [MASK_W-1:0] dqm
);
  localparam int RD_DLY = CAS_LAT - 2;

  logic              rd_launch;
  logic [MASK_W-1:0] rd_mask;

  generate
    if (RD_DLY == 0) begin : g_direct
      assign rd_launch = rd_go;
      assign rd_mask   = mask_in;
    end else begin : g_delay
      logic              v_q [RD_DLY];
      logic [MASK_W-1:0] m_q [RD_DLY];

      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[0] <= 1'b0;
          m_q[0] <= '1;
        end else begin
          v_q[0] <= rd_go;
          m_q[0] <= mask_in;
        end
      end

      for (genvar s = 1; s < RD_DLY; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            v_q[s] <= 1'b0;
            m_q[s] <= '1;
          end else begin
            v_q[s] <= v_q[s-1];
            m_q[s] <= m_q[s-1];
          end
        end
      end

      assign rd_launch = v_q[RD_DLY-1];
      assign rd_mask   = m_q[RD_DLY-1];
    end
  endgenerate

  logic [CNT_W-1:0]  beats_q;
  logic [MASK_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dqm     <= '1;
      hold_q  <= '1;
      beats_q <= '0;
    end else if (wr_go) begin
      dqm     <= mask_in;
      hold_q  <= mask_in;
      beats_q <= CNT_W'(BURST_LEN - 1);
    end else if (rd_launch) begin
      dqm     <= rd_mask;
      hold_q  <= rd_mask;
      beats_q <= CNT_W'(BURST_LEN - 1);
    end else if (beats_q != '0) begin
      dqm     <= hold_q;
      beats_q <= beats_q - 1'b1;
    end else begin
      dqm <= '1;
    end
  end

endmodule

// File: rtl/sdram_cmd_encoder.sv
`timescale 1ns/1ps
module sdram_cmd_encoder
  import sdcmd_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int BANK_W    = 2,
  parameter int MASK_W    = 4,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_addr,
  input  logic              req_auto_pre,
  input  logic              req_all_banks,
  input  logic [MASK_W-1:0] req_mask,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba,
  output logic              cke,
  output logic [MASK_W-1:0] dqm
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  sd_op_e            op_in, op_eff;
  logic              pass, desel, cke_nxt, burst_go;
  logic [3:0]        dec_pins;
  logic [ROW_W-1:0]  dec_addr;
  logic [BANK_W-1:0] dec_ba;

  assign op_in  = sd_op_e'(req_op);
  assign op_eff = pass ? op_in : OP_NOP;

  sdcmd_pwr #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_pwr (
    .clk      (clk),
    .rst      (rst),
    .op       (op_in),
    .pass     (pass),
    .desel    (desel),
    .cke_nxt  (cke_nxt),
    .burst_go (burst_go)
  );

  sdcmd_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_dec (
    .op        (op_eff),
    .bank      (req_bank),
    .addr_in   (req_addr),
    .auto_pre  (req_auto_pre),
    .all_banks (req_all_banks),
    .pins      (dec_pins),
    .addr_out  (dec_addr),
    .ba_out    (dec_ba)
  );

  sdcmd_mask #(.MASK_W(MASK_W), .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT),
               .CNT_W(CNT_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_go   (burst_go && op_in == OP_WR),
    .rd_go   (burst_go && op_in == OP_RD),
    .mask_in (req_mask),
    .dqm     (dqm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= PIN_DESEL;
      addr <= '0;
      ba   <= '0;
      cke  <= 1'b1;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= desel ? PIN_DESEL : dec_pins;
      addr <= dec_addr;
      ba   <= dec_ba;
      cke  <= cke_nxt;
    end
  end

endmodule

// File: rtl/sdcmd_checker.sv
`timescale 1ns/1ps
module sdcmd_checker #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int MASK_W    = 4,
  parameter int BURST_LEN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        req_op,
  input logic [ROW_W-1:0]  req_addr,
  input logic [MASK_W-1:0] req_mask,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ROW_W-1:0]  addr,
  input logic              cke,
  input logic [MASK_W-1:0] dqm
);
  localparam int CW = $clog2(BURST_LEN + 1);

  logic [3:0]  pins;
  logic        is_burst;
  logic [CW-1:0] win_q;

  assign pins     = {cs_n, ras_n, cas_n, we_n};
  assign is_burst = (pins == 4'b0101) || (pins == 4'b0100);

  // beats of the last read/write still outstanding, seen from the pins
  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else if (is_burst) win_q <= CW'(BURST_LEN - 1);
    else if (win_q != '0) win_q <= win_q - 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pins == 4'b1111 && cke && dqm == '1 && addr == '0));

  a_r2_act_full_row: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0011) |-> (addr == $past(req_addr)));

  a_r3_col_upper_zero: assert property (@(posedge clk) disable iff (rst)
    is_burst |-> (addr[ROW_W-2:COL_W] == '0));

  a_r7_write_mask_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0100) |-> (dqm == $past(req_mask)));

  a_r9_desel_when_down: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (pins == 4'b1111));

  a_r10_no_drop_in_burst: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> (win_q == '0));

  a_r11_stays_low: assert property (@(posedge clk) disable iff (rst)
    (!cke && req_op != 3'd6) |=> !cke);

  a_r11_exit_nop: assert property (@(posedge clk) disable iff (rst)
    (!cke && req_op == 3'd6) |=> (cke && pins == 4'b0111));

endmodule

bind sdram_cmd_encoder sdcmd_checker #(
  .ROW_W(ROW_W), .COL_W(COL_W), .MASK_W(MASK_W), .BURST_LEN(BURST_LEN)
) u_chk (
  .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
  .req_mask(req_mask), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .cke(cke), .dqm(dqm)
);

// File: tb/test_sdram_cmd_encoder.sv
`timescale 1ns/1ps
module test_sdram_cmd_encoder;
  localparam int BL = 4;
  localparam int CL = 3;
  localparam int RD = CL - 2;

  localparam int K_PIN = 0, K_ADDR = 1, K_BA = 2, K_CKE = 3, K_DQM = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  req_op = 3'd0;
  logic [1:0]  req_bank = 2'd0;
  logic [10:0] req_addr = '0;
  logic        req_auto_pre = 1'b0;
  logic        req_all_banks = 1'b0;
  logic [3:0]  req_mask = 4'hF;
  logic        cs_n, ras_n, cas_n, we_n, cke;
  logic [10:0] addr;
  logic [1:0]  ba;
  logic [3:0]  dqm;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct packed {
    int          at;
    int          kind;
    int          rq;
    logic [31:0] val;
  } exp_t;

  exp_t pend[$];

  sdram_cmd_encoder #(.BURST_LEN(BL), .CAS_LAT(CL)) i_sdram_cmd_encoder (
    .clk(clk), .rst(rst), .req_op(req_op), .req_bank(req_bank),
    .req_addr(req_addr), .req_auto_pre(req_auto_pre),
    .req_all_banks(req_all_banks), .req_mask(req_mask),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .cke(cke), .dqm(dqm)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] actual(int kind);
    case (kind)
      K_PIN:   return {28'd0, cs_n, ras_n, cas_n, we_n};
      K_ADDR:  return {21'd0, addr};
      K_BA:    return {30'd0, ba};
      K_CKE:   return {31'd0, cke};
      default: return {28'd0, dqm};
    endcase
  endfunction

  task automatic check(int rq, int kind, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d kind=%0d cycle=%0d actual=%0h expected=%0h",
               rq, kind, cyc, act, exp);
    end
  endtask

  task automatic want(int at, int kind, int rq, logic [31:0] v);
    exp_t e;
    e.at = at; e.kind = kind; e.rq = rq; e.val = v;
    pend.push_back(e);
  endtask

  // monitor: compare every expectation stamped for this cycle
  always @(negedge clk) begin
    if (!rst) begin
      exp_t keep[$];
      keep = {};
      foreach (pend[i]) begin
        if (pend[i].at == cyc)
          check(pend[i].rq, pend[i].kind, actual(pend[i].kind), pend[i].val);
        else
          keep.push_back(pend[i]);
      end
      pend = keep;
    end
  end

  // drive one request for one cycle (called at a falling edge)
  task automatic send(logic [2:0] op, logic [1:0] bk, logic [10:0] a,
                      logic ap, logic all, logic [3:0] m);
    req_op = op; req_bank = bk; req_addr = a;
    req_auto_pre = ap; req_all_banks = all; req_mask = m;
    @(negedge clk);
    req_op = 3'd0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, K_PIN, actual(K_PIN), 32'hF);
    check(1, K_CKE, actual(K_CKE), 32'h1);
    check(1, K_DQM, actual(K_DQM), 32'hF);
    check(1, K_ADDR, actual(K_ADDR), 32'h0);
    rst = 1'b0;

    // R5: nop
    n = cyc; want(n + 1, K_PIN, 5, 32'h7); want(n + 1, K_CKE, 5, 32'h1);
    send(3'd0, 2'd0, 11'h0, 1'b0, 1'b0, 4'hF);

    // R2 / R6: activate bank C (10), full row
    n = cyc; want(n + 1, K_PIN, 2, 32'h3); want(n + 1, K_ADDR, 2, 32'h5A5);
    want(n + 1, K_BA, 6, 32'h2);
    send(3'd1, 2'd2, 11'h5A5, 1'b1, 1'b1, 4'h0);
    // R2 / R6: activate bank B (01), all-ones row
    n = cyc; want(n + 1, K_PIN, 2, 32'h3); want(n + 1, K_ADDR, 2, 32'h7FF);
    want(n + 1, K_BA, 6, 32'h1);
    send(3'd1, 2'd1, 11'h7FF, 1'b0, 1'b0, 4'h0);
    idle(2);

    // R3 / R6 / R7: write bank D with auto-precharge, mask 0101
    n = cyc; want(n + 1, K_PIN, 3, 32'h4); want(n + 1, K_ADDR, 3, 32'h4C3);
    want(n + 1, K_BA, 6, 32'h3);
    for (int b = 1; b <= BL; b++) want(n + b, K_DQM, 7, 32'h5);
    want(n + BL + 1, K_DQM, 7, 32'hF);
    send(3'd3, 2'd3, 11'h7C3, 1'b1, 1'b0, 4'h5);
    idle(BL + 2);

    // R3 / R8: read bank A, upper address bits dropped, mask 1010
    n = cyc; want(n + 1, K_PIN, 3, 32'h5); want(n + 1, K_ADDR, 3, 32'h0BC);
    want(n + 1, K_BA, 6, 32'h0);
    for (int b = 1; b <= RD; b++) want(n + b, K_DQM, 8, 32'hF);
    for (int b = 1; b <= BL; b++) want(n + RD + b, K_DQM, 8, 32'hA);
    want(n + RD + BL + 1, K_DQM, 8, 32'hF);
    send(3'd2, 2'd0, 11'h7BC, 1'b0, 1'b0, 4'hA);
    idle(BL + RD + 2);

    // R4: precharge all, then single bank C
    n = cyc; want(n + 1, K_PIN, 4, 32'h2); want(n + 1, K_ADDR, 4, 32'h400);
    want(n + 1, K_BA, 4, 32'h0);
    send(3'd4, 2'd3, 11'h123, 1'b0, 1'b1, 4'hF);
    n = cyc; want(n + 1, K_PIN, 4, 32'h2); want(n + 1, K_ADDR, 4, 32'h000);
    want(n + 1, K_BA, 4, 32'h2);
    send(3'd4, 2'd2, 11'h7FF, 1'b1, 1'b0, 4'hF);

    // R9: power-down while idle
    n = cyc; want(n + 1, K_CKE, 9, 32'h0); want(n + 1, K_PIN, 9, 32'hF);
    send(3'd5, 2'd0, 11'h0, 1'b0, 1'b0, 4'hF);
    // R11: requests ignored while down
    n = cyc; want(n + 1, K_CKE, 11, 32'h0); want(n + 1, K_PIN, 11, 32'hF);
    send(3'd1, 2'd1, 11'h155, 1'b0, 1'b0, 4'hF);
    n = cyc; want(n + 1, K_CKE, 11, 32'h0); want(n + 1, K_DQM, 11, 32'hF);
    send(3'd3, 2'd1, 11'h055, 1'b0, 1'b0, 4'h0);
    idle(2);
    // R11: exit
    n = cyc; want(n + 1, K_CKE, 11, 32'h1); want(n + 1, K_PIN, 11, 32'h7);
    send(3'd6, 2'd0, 11'h0, 1'b0, 1'b0, 4'hF);
    idle(2);

    // R10: power-down requested right after a write is held off
    n = cyc;
    want(n + 1, K_PIN, 10, 32'h4);
    for (int b = 2; b <= BL + 1; b++) begin
      want(n + b, K_PIN, 10, 32'h7);
      want(n + b, K_CKE, 10, 32'h1);
    end
    want(n + BL + 2, K_CKE, 10, 32'h0);
    want(n + BL + 2, K_PIN, 10, 32'hF);
    send(3'd3, 2'd1, 11'h011, 1'b0, 1'b0, 4'h0);
    send(3'd5, 2'd0, 11'h0, 1'b0, 1'b0, 4'hF);
    send(3'd1, 2'd2, 11'h222, 1'b0, 1'b0, 4'hF);   // ignored during hold
    idle(BL + 1);
    n = cyc; want(n + 1, K_CKE, 11, 32'h1); want(n + 1, K_PIN, 11, 32'h7);
    send(3'd6, 2'd0, 11'h0, 1'b0, 1'b0, 4'hF);
    idle(3);

    if (pend.size() != 0) begin
      total++; bad++;
      $display("FAIL R1 pending expectations actual=%0d expected=0", pend.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule